// File: doc/BRIEF.md
# Split Code/Data Page Translator

This block maps a 16-bit virtual address to a 22-bit physical address through one of two page maps: instruction fetches go through the code map, and data reads and writes go through the data map. Each process therefore sees two independent 64 KB spaces. Pages are 2 KB. The low 11 address bits pass through unchanged, and the top 5 bits pick one of 32 entries in the selected map. An entry supplies an 11-bit frame number plus present, writable and user-accessible flags.

The lookup is combinational. When an access hits an absent page, the block reports a not-present fault so that a handler can bring the page in. When an access breaks the entry's permissions, the block reports a protection fault. On a fault, the virtual address and access type are captured in a register that software reads back. The table is loaded one entry per clock through a write port that only works in supervisor mode. Supervisor code may also turn translation off, in which case the virtual address is used directly.

Top module: `mmu_xlate`

## Requirements
- R1: After reset every table entry is absent and the fault capture registers read zero, so any translated access reports a not-present fault.
- R2: On a translated access with no fault, `pa_o` equals the entry's 11-bit frame number concatenated with `va_i[10:0]`.
- R3: The entry index is {code, `va_i[15:11]`}. The code bit is 1 only for a fetch (`acc_i`=0). Reads (`acc_i`=1), writes (`acc_i`=2) and the spare code 3 use the data map (code bit 0).
- R4: A table entry is 14 bits: bit 13 present, bit 12 writable, bit 11 user-accessible, bits 10:0 frame. An access to an entry with bit 13 clear gives `fault_o`=1 and `cause_o`=1.
- R5: A write to a present entry whose writable bit is clear gives `cause_o`=2, in both privilege modes.
- R6: A user-mode access (`sup_i`=0) to a present entry whose user bit is clear gives `cause_o`=2. Supervisor accesses ignore the user bit.
- R7: When an entry is absent and its permissions would also be broken, the not-present cause (1) wins.
- R8: A table write presented while `sup_i`=0 has no effect on the table.
- R9: With `sup_i`=1 and `xlate_en_i`=0, `pa_o` is `va_i` zero-extended and no fault is reported. In user mode `xlate_en_i` is ignored and translation stays on.
- R10: On a clock edge where `fault_o`=1, `flt_va_o` and `flt_acc_o` take `va_i` and `acc_i`. Otherwise they hold. With `req_i`=0, `fault_o` and `cause_o` are 0.
- R11: A supervisor table write takes effect at the clock edge that samples it. Lookups in the same cycle still see the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid |
| va_i | input | 16 | Virtual address |
| acc_i | input | 2 | Access type: 0 fetch, 1 read, 2 write |
| sup_i | input | 1 | Supervisor mode |
| xlate_en_i | input | 1 | Translation enable (honoured only in supervisor mode) |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | 6 | Table index {code, page} |
| tbl_data_i | input | 14 | Table entry {present, writable, user, frame} |
| pa_o | output | 22 | Physical address |
| fault_o | output | 1 | Fault on the current access |
| cause_o | output | 2 | 0 none, 1 not present, 2 protection |
| flt_va_o | output | 16 | Captured faulting virtual address |
| flt_acc_o | output | 2 | Captured faulting access type |

## Verification
The bench builds the block with its default parameters: 16-bit virtual addresses, 11 offset bits and 22-bit physical addresses. With these values the extremes are reachable. Page 31 of either map and frame 0x7FF test the top of both index ranges. An offset of 0x7FF shows that no bits carry from the offset into the frame field. Because the page count is small, the same page number can be loaded into both maps with different frames, which shows that fetches and data accesses never alias.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_READ  = 2'd1;
  localparam logic [1:0] ACC_WRITE = 2'd2;

  localparam logic [1:0] CAUSE_NONE   = 2'd0;
  localparam logic [1:0] CAUSE_ABSENT = 2'd1;
  localparam logic [1:0] CAUSE_PROT   = 2'd2;
endpackage

// File: rtl/mmu_table.sv
module mmu_table #(
  parameter int IDX_W = 6,
  parameter int ENT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [ENT_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [ENT_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0][ENT_W-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // R8: only the gated strobe may change storage
  a_r8_no_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
  // R11: written entry visible after the edge
  a_r11_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/mmu_check.sv
module mmu_check
  import mmu_pkg::*;
(
  input  logic       req_i,
  input  logic       bypass_i,
  input  logic       sup_i,
  input  logic [1:0] acc_i,
  input  logic       present_i,
  input  logic       writable_i,
  input  logic       user_ok_i,
  output logic [1:0] cause_o
);
  logic prot_viol;

  assign prot_viol = ((acc_i == ACC_WRITE) && !writable_i) || (!sup_i && !user_ok_i);

  always_comb begin
    cause_o = CAUSE_NONE;
    if (req_i && !bypass_i) begin
      if (!present_i)     cause_o = CAUSE_ABSENT;  // absent wins over protection
      else if (prot_viol) cause_o = CAUSE_PROT;
    end
  end

  // R7: an absent entry never yields a protection cause
  always_comb begin
    a_r7_absent_first: assert (present_i || cause_o != CAUSE_PROT);
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int OFF_W = 11,
  parameter int PA_W  = 22
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [VA_W-1:0]     va_i,
  input  logic [1:0]          acc_i,
  input  logic                sup_i,
  input  logic                xlate_en_i,
  input  logic                tbl_we_i,
  input  logic [VA_W-OFF_W:0] tbl_addr_i,
  input  logic [PA_W-OFF_W+2:0] tbl_data_i,
  output logic [PA_W-1:0]     pa_o,
  output logic                fault_o,
  output logic [1:0]          cause_o,
  output logic [VA_W-1:0]     flt_va_o,
  output logic [1:0]          flt_acc_o
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = VPN_W + 1;
  localparam int ENT_W = PFN_W + 3;
  localparam int B_PRES = ENT_W - 1;
  localparam int B_WR   = ENT_W - 2;
  localparam int B_USR  = ENT_W - 3;

  logic [IDX_W-1:0] ridx;
  logic [ENT_W-1:0] entry;
  logic             bypass;
  logic             tbl_we;

  assign tbl_we = tbl_we_i & sup_i;
  assign ridx   = {acc_i == ACC_FETCH, va_i[VA_W-1:OFF_W]};
  assign bypass = sup_i & ~xlate_en_i;

  mmu_table #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (ridx),
    .rdata_o (entry)
  );

  mmu_check u_check (
    .req_i      (req_i),
    .bypass_i   (bypass),
    .sup_i      (sup_i),
    .acc_i      (acc_i),
    .present_i  (entry[B_PRES]),
    .writable_i (entry[B_WR]),
    .user_ok_i  (entry[B_USR]),
    .cause_o    (cause_o)
  );

  assign fault_o = (cause_o != CAUSE_NONE);
  assign pa_o = bypass ? {{(PA_W-VA_W){1'b0}}, va_i}
                       : {entry[PFN_W-1:0], va_i[OFF_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_va_o  <= '0;
      flt_acc_o <= '0;
    end else if (fault_o) begin
      flt_va_o  <= va_i;
      flt_acc_o <= acc_i;
    end
  end

  // R2: offset bits pass through on a clean translation
  a_r2_offset_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !fault_o) |-> pa_o[OFF_W-1:0] == va_i[OFF_W-1:0]);
  // R9: bypass is fault-free and identity
  a_r9_bypass_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sup_i && !xlate_en_i) |-> (!fault_o && pa_o[VA_W-1:0] == va_i));
  // R10: capture on fault, hold otherwise
  a_r10_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> (flt_va_o == $past(va_i) && flt_acc_o == $past(acc_i)));
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |=> ($stable(flt_va_o) && $stable(flt_acc_o)));
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> cause_o == CAUSE_NONE);
endmodule

// File: tb/mmu_xlate_tb.sv
module mmu_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [15:0] va = '0;
  logic [1:0]  acc = '0;
  logic        sup = 1'b0;
  logic        en = 1'b1;
  logic        twe = 1'b0;
  logic [5:0]  taddr = '0;
  logic [13:0] tdata = '0;
  logic [21:0] pa;
  logic        fault;
  logic [1:0]  cause;
  logic [15:0] fva;
  logic [1:0]  facc;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mmu_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .va_i(va), .acc_i(acc),
    .sup_i(sup), .xlate_en_i(en), .tbl_we_i(twe), .tbl_addr_i(taddr),
    .tbl_data_i(tdata), .pa_o(pa), .fault_o(fault), .cause_o(cause),
    .flt_va_o(fva), .flt_acc_o(facc)
  );

  // vector: acc, sup, en, va, exp_fault, exp_cause, exp_pa
  localparam int NV = 15;
  localparam logic [44:0] VEC [NV] = '{
    {2'd1, 1'b0, 1'b1, 16'h0456, 1'b0, 2'd0, 11'h123, 11'h456}, // R2
    {2'd2, 1'b0, 1'b1, 16'h07FF, 1'b0, 2'd0, 11'h123, 11'h7FF}, // R2
    {2'd0, 1'b0, 1'b1, 16'h0010, 1'b0, 2'd0, 11'h400, 11'h010}, // R3
    {2'd0, 1'b0, 1'b1, 16'hF800, 1'b0, 2'd0, 11'h2AA, 11'h000}, // R3
    {2'd1, 1'b0, 1'b1, 16'hF800, 1'b1, 2'd1, 22'h0},            // R4
    {2'd1, 1'b0, 1'b1, 16'h0800, 1'b0, 2'd0, 11'h7FF, 11'h000}, // R2
    {2'd2, 1'b0, 1'b1, 16'h0801, 1'b1, 2'd2, 22'h0},            // R5
    {2'd2, 1'b1, 1'b1, 16'h0801, 1'b1, 2'd2, 22'h0},            // R5
    {2'd1, 1'b0, 1'b1, 16'h1000, 1'b1, 2'd2, 22'h0},            // R6
    {2'd1, 1'b1, 1'b1, 16'h1000, 1'b0, 2'd0, 11'h001, 11'h000}, // R6
    {2'd2, 1'b0, 1'b1, 16'h1800, 1'b1, 2'd1, 22'h0},            // R7
    {2'd0, 1'b0, 1'b1, 16'h0800, 1'b1, 2'd1, 22'h0},            // R3
    {2'd1, 1'b1, 1'b0, 16'hF800, 1'b0, 2'd0, 22'h00F800},       // R9
    {2'd1, 1'b0, 1'b0, 16'hF800, 1'b1, 2'd1, 22'h0},            // R9
    {2'd2, 1'b1, 1'b0, 16'h0801, 1'b0, 2'd0, 22'h000801}        // R9
  };

  function automatic logic [13:0] mk(input bit p, input bit w, input bit u,
                                     input logic [10:0] f);
    return {p, w, u, f};
  endfunction

  task automatic chk(input bit ok, input string req_tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic twrite(input bit s, input logic [5:0] a, input logic [13:0] d);
    @(negedge clk);
    sup = s; twe = 1'b1; taddr = a; tdata = d;
    @(posedge clk);
    #1 twe = 1'b0;
  endtask

  initial begin
    #40000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] pv;
    logic [1:0]  pa2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    chk(fva == 16'h0 && facc == 2'd0, "R1 capture reset", {14'h0, facc, fva}, 0);
    req = 1'b1; acc = 2'd1; va = 16'h0456; sup = 1'b0; en = 1'b1;
    #1 chk(fault && cause == 2'd1, "R1 empty table", cause, 1);
    @(negedge clk); req = 1'b0;

    twrite(1, 6'd0,  mk(1, 1, 1, 11'h123));
    twrite(1, 6'd1,  mk(1, 0, 1, 11'h7FF));
    twrite(1, 6'd2,  mk(1, 1, 0, 11'h001));
    twrite(1, 6'd3,  mk(0, 0, 0, 11'h555));
    twrite(1, 6'd32, mk(1, 0, 1, 11'h400));
    twrite(1, 6'd63, mk(1, 0, 1, 11'h2AA));

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      @(negedge clk);
      req = 1'b1; acc = v[44:43]; sup = v[42]; en = v[41]; va = v[40:25];
      pv = fva; pa2 = facc;
      #1;
      chk(fault == v[24] && cause == v[23:22], "R4-R9 vector cause",
          {fault, cause}, v[24:22]);
      if (!v[24]) chk(pa == v[21:0], "R2 vector address", pa, v[21:0]);
      @(posedge clk); #1;
      if (v[24]) chk(fva == v[40:25] && facc == v[44:43], "R10 capture",
                     {facc, fva}, v[44:25]);
      else chk(fva == pv && facc == pa2, "R10 hold", {facc, fva}, {pa2, pv});
    end

    // R10: no request means no fault and no capture
    @(negedge clk);
    req = 1'b0; acc = 2'd1; sup = 1'b0; en = 1'b1; va = 16'hF812;
    pv = fva;
    #1 chk(!fault && cause == 2'd0, "R10 idle quiet", cause, 0);
    @(posedge clk); #1 chk(fva == pv, "R10 idle no capture", fva, pv);

    // R8: user-mode table write ignored
    twrite(0, 6'd5, mk(1, 1, 1, 11'h0AB));
    @(negedge clk);
    req = 1'b1; sup = 1'b1; en = 1'b1; acc = 2'd1; va = 16'h2804;
    #1 chk(fault && cause == 2'd1, "R8 user write ignored", cause, 1);

    // R11: old entry seen in write cycle, new one after the edge
    @(negedge clk);
    twe = 1'b1; taddr = 6'd5; tdata = mk(1, 1, 1, 11'h0AB);
    #1 chk(cause == 2'd1, "R11 same cycle old", cause, 1);
    @(posedge clk); #1 twe = 1'b0;
    chk(!fault && pa == {11'h0AB, 11'h004}, "R11 after edge", pa, {11'h0AB, 11'h004});

    // R3: spare access code uses data map
    @(negedge clk);
    acc = 2'd3; va = 16'h0456; sup = 1'b0;
    #1 chk(!fault && pa == {11'h123, 11'h456}, "R3 spare code data map", pa,
           {11'h123, 11'h456});
    @(negedge clk); req = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule